// File: doc/BRIEF.md
# Phase Comparator with Lock-Controlled Charge-Pump Current

This block compares a reference pulse train against a feedback pulse train taken from a divided oscillator. It drives the enables of a charge pump in three states: it pumps up while the reference edge leads, pumps down while the feedback edge leads, and stays idle when the two edges line up. Both inputs are sampled on a fast local clock, so every phase error is measured as a whole number of clock periods.

A lock detector measures the width of every error pulse. The allowed width is chosen by a 2-bit threshold code. The detector also needs a set run of reference periods, chosen by a 2-bit delay code, before it declares lock. When the lock-detect enable is set, the block uses the low charge-pump current while locked. It returns to the high current as soon as one error pulse exceeds the threshold. When the enable is clear, a software bit selects the current directly. The selected current code and a high-current flag go to the analog pump. A digital output pin carries either the lock flag or a software data bit.

Top module: `pfd_lock_top`

## Requirements
- R1: A rising edge of ref_in sets up from the next clock. A rising edge of fb_in clears it. When fb_in rises later than ref_in by N sampled clock cycles, up is high for exactly N cycles. When both edges are sampled in the same cycle, neither up nor dn is asserted. up and dn are never high together.
- R2: When fb_in leads ref_in by N cycles, dn is high for exactly N cycles and up stays low.
- R3: The threshold code selects the largest allowed error pulse: code 0, 1, 2 and 3 give THR0..THR3 clock cycles. The defaults are 1, 2, 3 and 4 cycles, which is 10 to 40 ns at a 100 MHz sampling clock. An up or dn pulse longer than the selected limit is an over-threshold error.
- R4: The delay code selects how many consecutive reference rising edges without error must pass before in_lock rises. Code 1 needs 4 edges, code 2 needs 6 and code 3 needs 8. Code 0 behaves like code 3 and needs 8.
- R5: An over-threshold error clears in_lock on the next clock and restarts the count. The reference edge that ends the failing period is not counted.
- R6: Any change of the threshold code or the delay code clears in_lock and the count on the next clock.
- R7: With lock_en=1, cur_high is the inverse of in_lock. With lock_en=0, cur_high equals sw_high.
- R8: cur_code equals hi_code when cur_high=1. Otherwise it equals lo_code zero-extended, which is {2'b00, lo_code} at the default widths.
- R9: dout equals in_lock when out_sel=1 and equals sw_dout when out_sel=0.
- R10: After a synchronous reset, up=0, dn=0 and in_lock=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference pulse train |
| fb_in | input | 1 | Feedback (divided oscillator) pulse train |
| lock_en | input | 1 | Let the lock detector choose the pump current |
| sw_high | input | 1 | Software high-current select, used when lock_en=0 |
| thr_code | input | 2 | Phase-error threshold code |
| dly_code | input | 2 | Lock activation delay code |
| out_sel | input | 1 | 1: dout shows in_lock, 0: dout shows sw_dout |
| sw_dout | input | 1 | Software data bit for dout |
| hi_code | input | HI_W | High-current magnitude code (0.5 mA steps) |
| lo_code | input | LO_W | Low-current magnitude code (50 uA steps) |
| up | output | 1 | Charge-pump source enable |
| dn | output | 1 | Charge-pump sink enable |
| cur_code | output | HI_W | Selected current magnitude code |
| cur_high | output | 1 | High-current mode active |
| in_lock | output | 1 | Lock detector state |
| dout | output | 1 | Multiplexed digital output pin |

## Verification
Some properties are checked on every cycle. up and dn are never active together, and edges that arrive in the same cycle leave both idle. Any over-threshold error or any change of the threshold or delay code drops in_lock on the next clock, and in_lock can only rise on a reference edge. The scenarios alone show the rest: exact pulse widths for each lead direction, the number of good periods each delay code needs, the lost count after a failing period, and the current and output selection seen at the ports.

// File: rtl/pfd_pkg.sv
// Shared types for the phase comparator and lock detector.
// Assumes: codes are 2 bits wide, as the decode tables below require.
package pfd_pkg;
    typedef logic [1:0] code2_t;

    // Indices of the two sampled pulse inputs inside the comparator
    localparam int unsigned IDX_REF = 0;
    localparam int unsigned IDX_FB  = 1;
    localparam int unsigned N_PULSE = 2;
endpackage

// File: rtl/pfd_core.sv
// Three-state phase-frequency comparator.
// Detects rising edges of the reference and feedback inputs, sets up on a
// reference edge and dn on a feedback edge, and clears both once both are set.
// Assumes: inputs are already synchronous to clk; synchronous active-low reset.
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic ref_rise,
    output logic up,
    output logic dn
);
    logic [N_PULSE-1:0] pin;
    logic [N_PULSE-1:0] pin_q;
    logic [N_PULSE-1:0] rise;
    logic               up_nx;
    logic               dn_nx;

    assign pin[IDX_REF] = ref_in;
    assign pin[IDX_FB]  = fb_in;

    // One edge detector per pulse input
    for (genvar g = 0; g < N_PULSE; g++) begin : g_edge
        // Hold the previous sample of this input
        always_ff @(posedge clk) begin
            if (!rst_n) pin_q[g] <= 1'b0;
            else        pin_q[g] <= pin[g];
        end
        assign rise[g] = pin[g] & ~pin_q[g];
    end

    assign ref_rise = rise[IDX_REF];

    // Next state: set on own edge, both cleared when both would be set
    always_comb begin
        up_nx = up | rise[IDX_REF];
        dn_nx = dn | rise[IDX_FB];
        if (up_nx && dn_nx) begin
            up_nx = 1'b0;
            dn_nx = 1'b0;
        end
    end

    // Register the comparator state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_nx;
            dn <= dn_nx;
        end
    end

    p_not_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[IDX_REF] && rise[IDX_FB] && !up && !dn) |=> (!up && !dn));

    p_dn_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[IDX_FB] && !rise[IDX_REF] && !up) |=> dn);
endmodule

// File: rtl/pfd_lockdet.sv
// Lock detector: measures each up/dn pulse in clock cycles and compares it with
// the threshold chosen by thr_code. It counts consecutive reference edges
// without error and sets in_lock after the number chosen by dly_code.
// An error or a code change clears the lock at once.
// Assumes: THR* >= 1 and DLY* >= 1; synchronous active-low reset.
module pfd_lockdet
    import pfd_pkg::*;
#(
    parameter int unsigned THR0 = 1,
    parameter int unsigned THR1 = 2,
    parameter int unsigned THR2 = 3,
    parameter int unsigned THR3 = 4,
    parameter int unsigned DLY1 = 4,
    parameter int unsigned DLY2 = 6,
    parameter int unsigned DLY3 = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ref_rise,
    input  logic   err_on,
    input  code2_t thr_code,
    input  code2_t dly_code,
    output logic   in_lock
);
    localparam int unsigned THR_A   = (THR0 > THR1) ? THR0 : THR1;
    localparam int unsigned THR_B   = (THR2 > THR3) ? THR2 : THR3;
    localparam int unsigned THR_MAX = (THR_A > THR_B) ? THR_A : THR_B;
    localparam int unsigned WW      = $clog2(THR_MAX + 2);
    localparam int unsigned DLY_A   = (DLY1 > DLY2) ? DLY1 : DLY2;
    localparam int unsigned DLY_MAX = (DLY_A > DLY3) ? DLY_A : DLY3;
    localparam int unsigned GW      = $clog2(DLY_MAX + 1);

    logic [WW-1:0] wcnt;
    logic [WW-1:0] thr_lim;
    logic [GW-1:0] need;
    logic [GW-1:0] good;
    logic          bad_period;
    code2_t        thr_q;
    code2_t        dly_q;
    logic          over_now;
    logic          cfg_chg;

    // Decode the threshold code into a cycle limit
    always_comb begin
        unique case (thr_code)
            2'd0:    thr_lim = WW'(THR0);
            2'd1:    thr_lim = WW'(THR1);
            2'd2:    thr_lim = WW'(THR2);
            default: thr_lim = WW'(THR3);
        endcase
    end

    // Decode the delay code; the unused code takes the longest delay
    always_comb begin
        unique case (dly_code)
            2'd1:    need = GW'(DLY1);
            2'd2:    need = GW'(DLY2);
            default: need = GW'(DLY3);
        endcase
    end

    // Count cycles of the current error pulse, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                   wcnt <= '0;
        else if (!err_on)             wcnt <= '0;
        else if (wcnt != {WW{1'b1}})  wcnt <= wcnt + 1'b1;
    end

    assign over_now = err_on && (wcnt >= thr_lim);
    assign cfg_chg  = (thr_code != thr_q) || (dly_code != dly_q);

    // Good-period counter and lock state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good       <= '0;
            in_lock    <= 1'b0;
            bad_period <= 1'b0;
            thr_q      <= '0;
            dly_q      <= '0;
        end else begin
            thr_q <= thr_code;
            dly_q <= dly_code;
            if (cfg_chg) begin
                good       <= '0;
                in_lock    <= 1'b0;
                bad_period <= 1'b0;
            end else if (over_now) begin
                good       <= '0;
                in_lock    <= 1'b0;
                bad_period <= 1'b1;
            end else if (ref_rise) begin
                if (bad_period) begin
                    good       <= '0;
                    bad_period <= 1'b0;
                end else if (good >= need - 1'b1) begin
                    good    <= need;
                    in_lock <= 1'b1;
                end else begin
                    good <= good + 1'b1;
                end
            end
        end
    end

    p_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        over_now |=> !in_lock);

    p_rise_on_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_lock) |-> $past(ref_rise));

    p_cfg_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_code != $past(thr_code)) || (dly_code != $past(dly_code))) |=> !in_lock);
endmodule

// File: rtl/pfd_cursel.sv
// Current and output selection: picks high or low pump current, from the
// lock state or from software, and drives the multiplexed digital pin.
// Assumes: LO_W <= HI_W; purely combinational.
module pfd_cursel #(
    parameter int unsigned HI_W = 4,
    parameter int unsigned LO_W = 2
) (
    input  logic            lock_en,
    input  logic            sw_high,
    input  logic            in_lock,
    input  logic            out_sel,
    input  logic            sw_dout,
    input  logic [HI_W-1:0] hi_code,
    input  logic [LO_W-1:0] lo_code,
    output logic [HI_W-1:0] cur_code,
    output logic            cur_high,
    output logic            dout
);
    // Choose the current mode and code
    always_comb begin
        cur_high = lock_en ? !in_lock : sw_high;
        cur_code = cur_high ? hi_code : HI_W'(lo_code);
    end

    // Route the lock flag or the software bit to the pin
    always_comb begin
        dout = out_sel ? in_lock : sw_dout;
    end

    always_comb begin
        p_lock_low_r7: assert (!(lock_en && in_lock && cur_high));
    end
endmodule

// File: rtl/pfd_lock_top.sv
// Top: phase comparator, lock detector and current/output selection.
// Assumes: ref_in/fb_in are synchronous to clk; synchronous active-low reset.
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int unsigned HI_W = 4,
    parameter int unsigned LO_W = 2,
    parameter int unsigned THR0 = 1,
    parameter int unsigned THR1 = 2,
    parameter int unsigned THR2 = 3,
    parameter int unsigned THR3 = 4,
    parameter int unsigned DLY1 = 4,
    parameter int unsigned DLY2 = 6,
    parameter int unsigned DLY3 = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_in,
    input  logic            fb_in,
    input  logic            lock_en,
    input  logic            sw_high,
    input  logic [1:0]      thr_code,
    input  logic [1:0]      dly_code,
    input  logic            out_sel,
    input  logic            sw_dout,
    input  logic [HI_W-1:0] hi_code,
    input  logic [LO_W-1:0] lo_code,
    output logic            up,
    output logic            dn,
    output logic [HI_W-1:0] cur_code,
    output logic            cur_high,
    output logic            in_lock,
    output logic            dout
);
    logic ref_rise;

    pfd_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .fb_in    (fb_in),
        .ref_rise (ref_rise),
        .up       (up),
        .dn       (dn)
    );

    pfd_lockdet #(
        .THR0 (THR0), .THR1 (THR1), .THR2 (THR2), .THR3 (THR3),
        .DLY1 (DLY1), .DLY2 (DLY2), .DLY3 (DLY3)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (ref_rise),
        .err_on   (up | dn),
        .thr_code (thr_code),
        .dly_code (dly_code),
        .in_lock  (in_lock)
    );

    pfd_cursel #(.HI_W (HI_W), .LO_W (LO_W)) u_sel (
        .lock_en  (lock_en),
        .sw_high  (sw_high),
        .in_lock  (in_lock),
        .out_sel  (out_sel),
        .sw_dout  (sw_dout),
        .hi_code  (hi_code),
        .lo_code  (lo_code),
        .cur_code (cur_code),
        .cur_high (cur_high),
        .dout     (dout)
    );
endmodule

// File: tb/pfd_lock_top_bench.sv
module pfd_lock_top_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  PER = 20;

    logic clk = 1'b0;
    logic rst_n, ref_in, fb_in, lock_en, sw_high, out_sel, sw_dout;
    logic [1:0] thr_code, dly_code;
    logic [3:0] hi_code, cur_code;
    logic [1:0] lo_code;
    logic up, dn, cur_high, in_lock, dout;

    int checks = 0;
    int errors = 0;
    int up_w, dn_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_lock_top u_pfd_lock_top (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .lock_en(lock_en), .sw_high(sw_high), .thr_code(thr_code),
        .dly_code(dly_code), .out_sel(out_sel), .sw_dout(sw_dout),
        .hi_code(hi_code), .lo_code(lo_code), .up(up), .dn(dn),
        .cur_code(cur_code), .cur_high(cur_high), .in_lock(in_lock), .dout(dout)
    );

    typedef struct packed {
        logic [1:0] thr;
        logic [1:0] dly;
        logic signed [3:0] off;
        logic [4:0] n;
        logic lock;
    } vec_t;

    // thr, dly, feedback offset (cycles, + means fb lags), periods, expected lock
    localparam vec_t VEC [8] = '{
        '{2'd0, 2'd1,  4'sd1, 5'd4, 1'b1},
        '{2'd0, 2'd1,  4'sd2, 5'd6, 1'b0},
        '{2'd1, 2'd2, -4'sd2, 5'd6, 1'b1},
        '{2'd1, 2'd2, -4'sd2, 5'd5, 1'b0},
        '{2'd3, 2'd3,  4'sd4, 5'd8, 1'b1},
        '{2'd2, 2'd3,  4'sd4, 5'd8, 1'b0},
        '{2'd0, 2'd0,  4'sd0, 5'd7, 1'b0},
        '{2'd0, 2'd0,  4'sd0, 5'd8, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] t, input logic [1:0] d);
        @(negedge clk);
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        thr_code = t; dly_code = d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One reference period with feedback shifted by off cycles; measures up/dn widths
    task automatic period(input int off);
        up_w = 0; dn_w = 0;
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            if (up) up_w++;
            if (dn) dn_w++;
            ref_in = (c >= 5) && (c < 10);
            fb_in  = (c >= 5 + off) && (c < 10 + off);
        end
    endtask

    initial begin
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0; lock_en = 1'b1; sw_high = 1'b0;
        out_sel = 1'b0; sw_dout = 1'b0; thr_code = 2'd0; dly_code = 2'd1;
        hi_code = 4'hA; lo_code = 2'b11;
        do_reset(2'd0, 2'd1);
        // R10 reset state
        chk(up == 1'b0, "R10 up", up, 0);
        chk(dn == 1'b0, "R10 dn", dn, 0);
        chk(in_lock == 1'b0, "R10 in_lock", in_lock, 0);
        chk(cur_high == 1'b1, "R7 cur_high unlocked", cur_high, 1);
        chk(cur_code == 4'hA, "R8 cur_code high", cur_code, 10);

        // Table: R1/R2 widths, R3 thresholds, R4 delays
        for (int i = 0; i < 8; i++) begin
            int off;
            off = int'(VEC[i].off);
            do_reset(VEC[i].thr, VEC[i].dly);
            for (int p = 0; p < int'(VEC[i].n); p++) period(off);
            chk(up_w == (off > 0 ? off : 0), "R1 up width", up_w, off > 0 ? off : 0);
            chk(dn_w == (off < 0 ? -off : 0), "R2 dn width", dn_w, off < 0 ? -off : 0);
            chk(in_lock == VEC[i].lock, "R3/R4 lock after periods (R3 R4)", in_lock, VEC[i].lock);
        end

        // R5 immediate fallback and restart
        do_reset(2'd0, 2'd1);
        out_sel = 1'b1;
        repeat (4) period(1);
        chk(in_lock == 1'b1, "R4 locked", in_lock, 1);
        chk(cur_high == 1'b0, "R7 low current when locked", cur_high, 0);
        chk(cur_code == 4'b0011, "R8 low code", cur_code, 3);
        chk(dout == 1'b1, "R9 dout shows lock", dout, 1);
        period(3);
        chk(in_lock == 1'b0, "R5 lock dropped", in_lock, 0);
        chk(cur_high == 1'b1, "R7 back to high current", cur_high, 1);
        chk(cur_code == 4'hA, "R8 high code", cur_code, 10);
        repeat (4) period(1);
        chk(in_lock == 1'b0, "R5 failing edge not counted", in_lock, 0);
        period(1);
        chk(in_lock == 1'b1, "R5 relocked", in_lock, 1);

        // R6 code change clears lock
        @(negedge clk);
        thr_code = 2'd1;
        @(negedge clk);
        chk(in_lock == 1'b0, "R6 thr change clears", in_lock, 0);
        repeat (4) period(1);
        chk(in_lock == 1'b1, "R6 relock", in_lock, 1);
        @(negedge clk);
        dly_code = 2'd2;
        @(negedge clk);
        chk(in_lock == 1'b0, "R6 dly change clears", in_lock, 0);

        // R7 software current select, R9 software output
        lock_en = 1'b0; sw_high = 1'b1; out_sel = 1'b0; sw_dout = 1'b1;
        #1;
        chk(cur_high == 1'b1, "R7 sw high", cur_high, 1);
        chk(dout == 1'b1, "R9 sw dout 1", dout, 1);
        sw_high = 1'b0; sw_dout = 1'b0;
        #1;
        chk(cur_high == 1'b0, "R7 sw low", cur_high, 0);
        chk(cur_code == 4'b0011, "R8 sw low code", cur_code, 3);
        chk(dout == 1'b0, "R9 sw dout 0", dout, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule